// File: doc/BRIEF.md
# Single-Channel Word DMA Engine

This block is one DMA channel that copies 32-bit words between a peripheral-side address space and a memory-side address space. Software sets it up through a small register port. It writes a peripheral pointer, a memory pointer, a control word and a sequencing word. A status word reports progress. Each word is read from the source side and then written to the destination side. Both sides use a simple request/acknowledge handshake that stands in for the real buses.

There are three ways to run the channel. One-shot mode stops by itself once the count is done. Continuous single-buffer mode restarts at every end-of-count. Continuous double-buffer mode signals once at the half-way mark and again at the end. In both continuous modes, pointer values written during a run are held back until a reload boundary, so the next buffer can be staged while the current one moves.

Three further controls shape a run. Flow control ties word movement to one of 32 peripheral request lines, in bursts of 1, 4 or 8 words. A memory-side wrap length keeps the destination inside a ring. A global run bit pauses the channel and freezes the remaining count so that it can be read exactly.

Top module: `dma_chan`

## Requirements
- R1: After reset, every register offset (0 global, 1 control, 2 status, 3 peripheral pointer, 4 memory pointer, 5 sequencing) reads zero, no request is raised and the interrupt is low.
- R2: Each word is first read from the source side and then written unchanged to the destination side. Control bit 28 selects the direction: 1 means peripheral to memory, 0 means memory to peripheral. Both pointers advance by 4 bytes per word. Address bits 1:0 always read and drive as zero, whatever was written.
- R3: Control word layout: bit 31 enable, bit 30 one-shot, bit 29 end-of-count interrupt enable, bit 28 direction, bit 21 flow control, bits 20:16 request select, bits 15:2 word count minus one. In one-shot mode the channel moves exactly count+1 words and then clears its enable. Enable reads 0 afterwards and busy drops.
- R4: Status layout: bit 31 busy, bit 30 end-of-count (sticky), bits 15:2 remaining words minus one. Writing 1 to bit 30 clears the flag. If such a write lands in the same cycle as a new end-of-count, the flag stays set.
- R5: The interrupt output is high exactly when the end-of-count flag and its enable are both set.
- R6: Global register bit 31 gates the channel. While it is 0, no new word starts, a word already in flight completes, and the remaining count does not change. Setting it back to 1 resumes the transfer.
- R7: With flow control on, a burst starts only while the request line picked by the request select field is high. Other lines have no effect.
- R8: Sequencing bits 1:0 set the burst length: 1 means 4 words, 2 means 8 words, and any other value means 1 word. A single request pulse moves exactly one burst, or fewer if the count runs out first.
- R9: Sequencing bits 18:16 pick the memory wrap length: 0 means no wrap, and a value k from 1 to 7 means 16<<k words. After that many words the memory address returns to its start.
- R10: In continuous single-buffer mode (one-shot 0, sequencing bit 2 clear), each end-of-count reloads both pointers from the last written values and reloads the count, and the channel stays busy.
- R11: In continuous double-buffer mode (sequencing bit 2 set), the first end-of-count reloads only the count and the pointers carry on. The second end-of-count reloads the pointers as well.
- R12: Writing enable 0 lets the word in flight finish. After that the channel raises no further requests, busy drops and the remaining count stays put.
- R13: Pointer writes are held as staged values. Reading offsets 3 and 4 returns the staged value. A running transfer picks the staged value up only when the channel is enabled or at a reload boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dreq | input | 32 | Peripheral request lines |
| per_req | output | 1 | Peripheral-side access request |
| per_we | output | 1 | Peripheral-side access is a write |
| per_addr | output | 32 | Peripheral-side byte address |
| per_wdata | output | 32 | Peripheral-side write data |
| per_rdata | input | 32 | Peripheral-side read data |
| per_ack | input | 1 | Peripheral-side access accepted |
| mem_req | output | 1 | Memory-side access request |
| mem_we | output | 1 | Memory-side access is a write |
| mem_addr | output | 32 | Memory-side byte address |
| mem_wdata | output | 32 | Memory-side write data |
| mem_rdata | input | 32 | Memory-side read data |
| mem_ack | input | 1 | Memory-side access accepted |
| irq | output | 1 | End-of-count interrupt |

## Verification
The two functions that can meet in one cycle are the completion of the final word, which sets the end-of-count flag, and a software write that clears that flag. The bench provokes the collision by polling the status word while a one-shot run is in progress. It issues the clear write at the falling edge where the destination write of the final word is pending and the remaining count reads zero, so that both actions take effect on the same rising edge. The run is judged correct when the flag still reads set afterwards. A second, lone clear write must then bring it to zero.

// File: rtl/dma_chan.sv
module dma_chan (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [31:0] dreq,
  output logic        per_req,
  output logic        per_we,
  output logic [31:0] per_addr,
  output logic [31:0] per_wdata,
  input  logic [31:0] per_rdata,
  input  logic        per_ack,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        irq
);

  localparam int CW = 14;
  localparam int PW = 30;
  localparam int BW = 3;
  localparam logic [2:0] A_GEN = 3'd0, A_CTL = 3'd1, A_STA = 3'd2,
                         A_PPTR = 3'd3, A_MPTR = 3'd4, A_SEQ = 3'd5;

  typedef enum logic [1:0] {P_IDLE, P_RD, P_WR} phase_t;

  phase_t          phase;
  logic            run, en, oneshot, ie, to_mem, flow, dbl, eoc, half;
  logic [4:0]      sel;
  logic [CW-1:0]   cnt, rem, mem_off;
  logic [1:0]      burst;
  logic [2:0]      wrap;
  logic [PW-1:0]   per_base, mem_base, per_cur, mem_start;
  logic [BW-1:0]   blft;
  logic [31:0]     data_q;

  logic wr_gen, wr_ctl, wr_sta, wr_pp, wr_mp, wr_seq;
  assign wr_gen = reg_we && reg_addr == A_GEN;
  assign wr_ctl = reg_we && reg_addr == A_CTL;
  assign wr_sta = reg_we && reg_addr == A_STA;
  assign wr_pp  = reg_we && reg_addr == A_PPTR;
  assign wr_mp  = reg_we && reg_addr == A_MPTR;
  assign wr_seq = reg_we && reg_addr == A_SEQ;

  logic          gate, src_ack, dst_ack, done, last, start, en_nxt, busy;
  logic [BW-1:0] blen_m1;
  logic [CW-1:0] wrap_len, off_inc, off_nxt;
  logic [PW-1:0] mem_cur;
  logic [31:0]   src_data;

  assign gate     = !flow || dreq[sel];
  assign blen_m1  = (burst == 2'd1) ? BW'(3) : (burst == 2'd2) ? BW'(7) : BW'(0);
  assign wrap_len = CW'(16) << wrap;
  assign off_inc  = mem_off + CW'(1);
  assign off_nxt  = (wrap != 3'd0 && off_inc == wrap_len) ? '0 : off_inc;
  assign mem_cur  = mem_start + PW'(mem_off);
  assign src_ack  = to_mem ? per_ack : mem_ack;
  assign dst_ack  = to_mem ? mem_ack : per_ack;
  assign src_data = to_mem ? per_rdata : mem_rdata;
  assign done     = phase == P_WR && dst_ack;
  assign last     = rem == '0;
  assign start    = wr_ctl && reg_wdata[31] && !en;
  assign busy     = en || phase != P_IDLE;

  always_comb begin
    en_nxt = wr_ctl ? reg_wdata[31] : en;
    if (done && last && oneshot) en_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_IDLE;
      run <= 1'b0; en <= 1'b0; oneshot <= 1'b0; ie <= 1'b0;
      to_mem <= 1'b0; flow <= 1'b0; dbl <= 1'b0; eoc <= 1'b0; half <= 1'b0;
      sel <= '0; cnt <= '0; rem <= '0; mem_off <= '0;
      burst <= '0; wrap <= '0; blft <= '0; data_q <= '0;
      per_base <= '0; mem_base <= '0; per_cur <= '0; mem_start <= '0;
    end else begin
      if (wr_gen) run <= reg_wdata[31];
      if (wr_ctl) begin
        oneshot <= reg_wdata[30];
        ie      <= reg_wdata[29];
        to_mem  <= reg_wdata[28];
        flow    <= reg_wdata[21];
        sel     <= reg_wdata[20:16];
        cnt     <= reg_wdata[15:2];
      end
      en <= en_nxt;
      if (wr_seq) begin
        burst <= reg_wdata[1:0];
        dbl   <= reg_wdata[2];
        wrap  <= reg_wdata[18:16];
      end
      if (wr_pp) per_base <= reg_wdata[31:2];
      if (wr_mp) mem_base <= reg_wdata[31:2];

      if (done && last) eoc <= 1'b1;
      else if (wr_sta && reg_wdata[30]) eoc <= 1'b0;

      case (phase)
        P_IDLE: if (en && run && gate) begin
          phase <= P_RD;
          blft  <= blen_m1;
        end
        P_RD: if (src_ack) begin
          data_q <= src_data;
          phase  <= P_WR;
        end
        P_WR: if (dst_ack) begin
          if (blft != '0 && !last && en_nxt && run) begin
            phase <= P_RD;
            blft  <= blft - BW'(1);
          end else begin
            phase <= P_IDLE;
          end
        end
        default: phase <= P_IDLE;
      endcase

      if (start) begin
        per_cur   <= per_base;
        mem_start <= mem_base;
        mem_off   <= '0;
        rem       <= reg_wdata[15:2];
        half      <= 1'b0;
      end else if (done) begin
        per_cur <= per_cur + PW'(1);
        mem_off <= off_nxt;
        if (!last) begin
          rem <= rem - CW'(1);
        end else if (!oneshot) begin
          rem <= cnt;
          if (dbl && !half) begin
            half <= 1'b1;
          end else begin
            half      <= 1'b0;
            per_cur   <= per_base;
            mem_start <= mem_base;
            mem_off   <= '0;
          end
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_GEN:   reg_rdata = {run, 31'd0};
      A_CTL:   reg_rdata = {en, oneshot, ie, to_mem, 6'd0, flow, sel, cnt, 2'b00};
      A_STA:   reg_rdata = {busy, eoc, 14'd0, rem, 2'b00};
      A_PPTR:  reg_rdata = {per_base, 2'b00};
      A_MPTR:  reg_rdata = {mem_base, 2'b00};
      A_SEQ:   reg_rdata = {13'd0, wrap, 13'd0, dbl, burst};
      default: reg_rdata = '0;
    endcase
  end

  assign per_req   = (phase == P_RD && to_mem) || (phase == P_WR && !to_mem);
  assign per_we    = phase == P_WR && !to_mem;
  assign mem_req   = (phase == P_RD && !to_mem) || (phase == P_WR && to_mem);
  assign mem_we    = phase == P_WR && to_mem;
  assign per_addr  = {per_cur, 2'b00};
  assign mem_addr  = {mem_cur, 2'b00};
  assign per_wdata = data_q;
  assign mem_wdata = data_q;
  assign irq       = eoc && ie;

  assert_one_side_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(per_req && mem_req));

  assert_eoc_clear_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc) |-> $past(reg_we && reg_addr == A_STA && reg_wdata[30]));

  assert_paused_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && phase == P_IDLE) |=> phase == P_IDLE);

  assert_paused_count_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && phase == P_IDLE && !reg_we) |=> $stable(rem));

  assert_flow_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_RD && $past(phase == P_IDLE)) |-> $past(!flow || dreq[sel]));

  assert_enable_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> $past((reg_we && reg_addr == A_CTL && !reg_wdata[31]) ||
                        (oneshot && rem == '0)));

endmodule

// File: tb/dma_chan_bench.sv
module dma_chan_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] dreq = 32'd0;
  wire  [31:0] reg_rdata;
  wire         per_req, per_we, mem_req, mem_we, irq;
  wire  [31:0] per_addr, per_wdata, mem_addr, mem_wdata;

  logic [31:0] per_mem [0:255];
  logic [31:0] mem_mem [0:255];
  wire  [31:0] per_rdata = per_mem[per_addr[9:2]];
  wire  [31:0] mem_rdata = mem_mem[mem_addr[9:2]];
  wire         per_ack = per_req;
  wire         mem_ack = mem_req;

  logic        log_clr = 1'b0;
  int          logn;
  logic [31:0] log_a [0:15];
  logic [31:0] log_d [0:15];

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] v, a0, b0, c0;

  dma_chan u_dma_chan (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dreq(dreq),
    .per_req(per_req), .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
    .per_rdata(per_rdata), .per_ack(per_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .irq(irq)
  );

  function automatic logic [31:0] pval(int i); return 32'hC0DE_0000 + i; endfunction
  function automatic logic [31:0] mval(int i); return 32'h5A00_0000 + i; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin
        per_mem[i] <= pval(i);
        mem_mem[i] <= mval(i);
      end
      logn <= 0;
    end else begin
      if (per_req && per_we) per_mem[per_addr[9:2]] <= per_wdata;
      if (mem_req && mem_we) mem_mem[mem_addr[9:2]] <= mem_wdata;
      if (log_clr) logn <= 0;
      else if (mem_req && mem_we) begin
        if (logn < 16) begin
          log_a[logn[3:0]] <= mem_addr;
          log_d[logn[3:0]] <= mem_wdata;
        end
        logn <= logn + 1;
      end
    end
  end

  function automatic logic [31:0] ctlw(bit e, bit os, bit ie, bit tm, bit fl,
                                       logic [4:0] s, logic [13:0] c);
    return {e, os, ie, tm, 6'd0, fl, s, c, 2'b00};
  endfunction

  function automatic logic [31:0] seqw(logic [1:0] b, bit d, logic [2:0] w);
    return {13'd0, w, 13'd0, d, b};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int k = 0; k < 4000; k++) begin
      rd(3'd2, s);
      if (!s[31]) break;
      @(negedge clk);
    end
  endtask

  task automatic pulse(int line);
    @(negedge clk);
    dreq = 32'd1 << line;
    @(negedge clk);
    dreq = 32'd0;
  endtask

  task automatic clear_log();
    @(negedge clk);
    log_clr = 1'b1;
    @(negedge clk);
    log_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 6; r++) begin
      rd(3'(r), v);
      chk($sformatf("R1 reset read offset %0d", r), v, 32'd0);
    end
    chk("R1 reset irq", {31'd0, irq}, 32'd0);
    chk("R1 reset requests", {30'd0, per_req, mem_req}, 32'd0);

    wr(3'd0, 32'h8000_0000);
    rd(3'd0, v); chk("R6 global run readback", v, 32'h8000_0000);
    wr(3'd3, 32'h0000_0103);
    rd(3'd3, v); chk("R2 pointer low bits dropped", v, 32'h0000_0100);

    // one-shot, peripheral to memory, 5 words
    wr(3'd5, 32'd0); wr(3'd3, 32'h0); wr(3'd4, 32'h100);
    wr(3'd1, ctlw(1, 1, 1, 1, 0, 5'd0, 14'd4));
    wait_done();
    for (int i = 0; i < 5; i++)
      chk($sformatf("R2 p2m word %0d", i), mem_mem[64 + i], pval(i));
    chk("R3 no word past count", mem_mem[69], mval(69));
    rd(3'd2, v); chk("R3 one-shot status", v, 32'h4000_0000);
    rd(3'd1, v); chk("R3 enable cleared", v, ctlw(0, 1, 1, 1, 0, 5'd0, 14'd4));
    chk("R5 irq with enable", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'h4000_0000);
    rd(3'd2, v); chk("R4 write-one clears flag", v, 32'd0);
    chk("R5 irq after clear", {31'd0, irq}, 32'd0);

    // one-shot, memory to peripheral, 3 words, irq disabled
    wr(3'd3, 32'h200); wr(3'd4, 32'h0);
    wr(3'd1, ctlw(1, 1, 0, 0, 0, 5'd0, 14'd2));
    wait_done();
    for (int i = 0; i < 3; i++)
      chk($sformatf("R2 m2p word %0d", i), per_mem[128 + i], mval(i));
    chk("R3 m2p stops at count", per_mem[131], pval(131));
    rd(3'd2, v); chk("R4 flag set", {31'd0, v[30]}, 32'd1);
    chk("R5 irq masked", {31'd0, irq}, 32'd0);

    // wrap sweep: none and 32 words, 40 words moved
    for (int w = 0; w < 2; w++) begin
      int base;
      base = (w == 0) ? 192 : 128;
      wr(3'd5, seqw(2'd0, 1'b0, 3'(w)));
      wr(3'd3, 32'h0); wr(3'd4, 32'(base * 4));
      wr(3'd1, ctlw(1, 1, 0, 1, 0, 5'd0, 14'd39));
      wait_done();
      if (w == 0) begin
        for (int j = 0; j < 40; j++)
          chk($sformatf("R9 no wrap word %0d", j), mem_mem[base + j], pval(j));
        chk("R9 no wrap end", mem_mem[base + 40], mval(base + 40));
      end else begin
        for (int j = 0; j < 32; j++)
          chk($sformatf("R9 wrap32 slot %0d", j), mem_mem[base + j],
              (j < 8) ? pval(j + 32) : pval(j));
        chk("R9 wrap32 stays in ring", mem_mem[base + 32], mval(base + 32));
      end
    end

    // flow control and burst sweep
    for (int b = 0; b < 3; b++) begin
      int blen;
      blen = (b == 0) ? 1 : (b == 1) ? 4 : 8;
      wr(3'd5, seqw(2'(b), 1'b0, 3'd0));
      wr(3'd3, 32'h0); wr(3'd4, 32'h0);
      wr(3'd1, ctlw(1, 1, 0, 1, 1, 5'd7, 14'd19));
      idle(6);
      rd(3'd2, v); chk($sformatf("R7 waits for request b=%0d", b), {18'd0, v[15:2]}, 32'd19);
      pulse(8); idle(6);
      rd(3'd2, v); chk($sformatf("R7 other line ignored b=%0d", b), {18'd0, v[15:2]}, 32'd19);
      pulse(7); idle(25);
      rd(3'd2, v); chk($sformatf("R8 one burst b=%0d", b), {18'd0, v[15:2]}, 32'(19 - blen));
      pulse(7); idle(25);
      rd(3'd2, v); chk($sformatf("R8 two bursts b=%0d", b), {18'd0, v[15:2]}, 32'(19 - 2 * blen));
      wr(3'd1, ctlw(0, 1, 0, 1, 1, 5'd7, 14'd19));
      idle(2);
    end

    // global pause in continuous single mode
    wr(3'd5, 32'd0); wr(3'd3, 32'h0); wr(3'd4, 32'h0);
    wr(3'd1, ctlw(1, 0, 0, 1, 0, 5'd0, 14'd99));
    idle(10);
    wr(3'd0, 32'd0);
    idle(3);
    rd(3'd2, a0);
    begin
      bit seen;
      seen = 1'b0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (per_req || mem_req) seen = 1'b1;
      end
      chk("R6 no request while paused", {31'd0, seen}, 32'd0);
    end
    rd(3'd2, b0);
    chk("R6 count frozen", {18'd0, b0[15:2]}, {18'd0, a0[15:2]});
    chk("R6 progress before pause", {31'd0, a0[15:2] < 14'd99}, 32'd1);
    wr(3'd0, 32'h8000_0000);
    idle(6);
    rd(3'd2, c0);
    chk("R6 resumes", {31'd0, c0[15:2] < a0[15:2]}, 32'd1);

    // clearing enable mid-run
    wr(3'd1, ctlw(0, 0, 0, 1, 0, 5'd0, 14'd99));
    idle(2);
    rd(3'd2, a0);
    chk("R12 busy dropped", {31'd0, a0[31]}, 32'd0);
    begin
      bit seen;
      seen = 1'b0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (per_req || mem_req) seen = 1'b1;
      end
      chk("R12 no request after disable", {31'd0, seen}, 32'd0);
    end
    rd(3'd2, b0);
    chk("R12 count holds", {18'd0, b0[15:2]}, {18'd0, a0[15:2]});

    // collision: flag set by final word and cleared by software in one cycle
    wr(3'd3, 32'h0); wr(3'd4, 32'h3C0);
    wr(3'd1, ctlw(1, 1, 0, 1, 0, 5'd0, 14'd3));
    begin
      bit hit;
      hit = 1'b0;
      for (int k = 0; k < 100 && !hit; k++) begin
        @(negedge clk);
        reg_addr = 3'd2;
        #1;
        if (mem_req && mem_we && reg_rdata[15:2] == 14'd0) begin
          reg_we = 1'b1; reg_wdata = 32'h4000_0000;
          @(negedge clk);
          reg_we = 1'b0;
          hit = 1'b1;
        end
      end
      chk("R4 collision reached", {31'd0, hit}, 32'd1);
    end
    rd(3'd2, v); chk("R4 set wins over clear", v, 32'h4000_0000);
    wr(3'd2, 32'h4000_0000);
    rd(3'd2, v); chk("R4 lone clear", v, 32'd0);

    // continuous single with staged pointers
    wr(3'd5, 32'd0); wr(3'd3, 32'h0); wr(3'd4, 32'h40);
    clear_log();
    wr(3'd1, ctlw(1, 0, 0, 1, 0, 5'd0, 14'd3));
    wr(3'd3, 32'h80); wr(3'd4, 32'h300);
    rd(3'd4, v); chk("R13 staged readback", v, 32'h300);
    idle(20);
    rd(3'd2, v); chk("R10 still busy after end", {31'd0, v[31]}, 32'd1);
    wr(3'd1, ctlw(0, 0, 0, 1, 0, 5'd0, 14'd3));
    idle(3);
    chk("R10 enough words logged", {31'd0, logn >= 8}, 32'd1);
    for (int i = 0; i < 4; i++)
      chk($sformatf("R13 old buffer addr %0d", i), log_a[i], 32'h40 + 32'(4 * i));
    for (int i = 0; i < 4; i++)
      chk($sformatf("R10 reloaded addr %0d", i), log_a[4 + i], 32'h300 + 32'(4 * i));
    chk("R10 reloaded source data", log_d[4], pval(32));
    chk("R13 first data", log_d[0], pval(0));

    // continuous double buffer
    wr(3'd5, seqw(2'd0, 1'b1, 3'd0)); wr(3'd3, 32'h0); wr(3'd4, 32'h0);
    clear_log();
    wr(3'd1, ctlw(1, 0, 1, 1, 0, 5'd0, 14'd2));
    wr(3'd4, 32'h200);
    idle(30);
    wr(3'd1, ctlw(0, 0, 1, 1, 0, 5'd0, 14'd2));
    idle(3);
    for (int i = 0; i < 6; i++)
      chk($sformatf("R11 both halves addr %0d", i), log_a[i], 32'(4 * i));
    chk("R11 second half continues source", log_d[3], pval(3));
    chk("R11 reload after full", log_a[6], 32'h200);
    chk("R11 reload next", log_a[7], 32'h204);
    chk("R11 reloaded source", log_d[6], pval(0));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule